// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block builds flow-control PAUSE frames for a transmit MAC and presents them as a byte stream. Two kinds of frame are made. An XOFF frame asks the link partner to stop sending for a programmed number of quanta; one quanta is 512 bit times. An XON frame carries a quanta of zero and releases the partner at once. Every frame is 60 bytes long. The frame check sequence is appended further down the line.

A frame can be requested in two ways. Software can pulse a command input for either kind. The receive FIFO can also trigger frames: when it reports full, an XOFF is queued, and when the full indication clears, an XON is queued. A configuration input turns off this FIFO-driven behaviour.

Pending work is announced on a request line. The MAC answers with a grant only at a boundary between client frames, so a pause frame never cuts into client traffic. If both kinds are pending when the grant arrives, XOFF is sent first and the XON stays queued.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, `pauseReq`, `txValid`, `txFirst` and `txLast` are all 0.
- R2: After a grant is accepted, the frame is streamed as one byte per cycle with `txValid` high. The first byte appears in the cycle after the accepting clock edge. There are exactly 60 bytes. `txFirst` marks byte 0 and `txLast` marks byte 59, and `txValid` is low in the cycle after byte 59.
- R3: The byte layout is as follows. Bytes 0..5 are the destination 01 80 C2 00 00 01. Bytes 6..11 are `stationAddr`, bits 47:40 first. Bytes 12..13 are the type 88 08. Bytes 14..15 are the opcode 00 01.
- R4: In an XOFF frame, bytes 16..17 carry `pauseQuanta` as sampled at the accepting edge, most significant byte first. Bytes 18..59 are zero.
- R5: In an XON frame, bytes 16..17 are 00 00, and all other bytes follow R3 and R4.
- R6: When `noPauseFifo` is 0, a 0-to-1 change of `rxFifoFull` queues an XOFF and a 1-to-0 change queues an XON. Each queued frame raises `pauseReq`.
- R7: When `noPauseFifo` is 1, changes of `rxFifoFull` queue nothing. `pauseReq` stays low unless a command is pulsed.
- R8: If XOFF and XON are both pending at the grant, the XOFF frame is sent. The XON stays pending and is requested again after that frame ends.
- R9: `pauseReq` stays high until a grant is accepted. No frame starts without a grant. A `pauseGrant` pulse while `pauseReq` is low has no effect.
- R10: `pauseReq` is low while a frame is being output. A command that arrives during a frame is kept and requested in the cycle after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdXoff | input | 1 | One-cycle pulse that queues an XOFF frame |
| cmdXon | input | 1 | One-cycle pulse that queues an XON frame |
| rxFifoFull | input | 1 | Full indication from the receive FIFO |
| noPauseFifo | input | 1 | 1 turns off FIFO-driven pause generation |
| pauseQuanta | input | 16 | Quanta placed in XOFF frames |
| stationAddr | input | 48 | Source address of the frames |
| pauseReq | output | 1 | A pause frame is waiting to be sent |
| pauseGrant | input | 1 | MAC grant, given only at a frame boundary |
| txValid | output | 1 | A frame byte is on `txData` |
| txData | output | 8 | Frame byte |
| txFirst | output | 1 | Marks byte 0 of the frame |
| txLast | output | 1 | Marks the final byte of the frame |

## Verification
A command or a FIFO full transition that is sampled at a clock edge shows up on `pauseReq` right after that edge. This is because the request is a combinational view of the pending flags. Byte k of a frame is due k cycles after the first byte, and the first byte is due one cycle after the edge that accepts the grant. `txValid` drops 60 cycles after that edge. The bench drives its inputs on the falling edge and reads outputs on the next falling edge, so each check lands half a cycle after the edge that is supposed to produce the value.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic start;    // begin a frame this cycle
    logic sendXon;  // 1: zero quanta, 0: programmed quanta
  } pauseStrobe_t;

  localparam logic [47:0] PAUSE_DEST = 48'h0180C2000001;
  localparam logic [15:0] PAUSE_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
endpackage

// File: rtl/pause_req_ctrl.sv
module pause_req_ctrl
  import pause_gen_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cmdXoff,
  input  logic cmdXon,
  input  logic rxFifoFull,
  input  logic noPauseFifo,
  input  logic pauseGrant,
  input  logic dpBusy,
  output logic pauseReq,
  output pauseStrobe_t strobe
);
  logic xoffPend, xonPend, fifoFullQ;
  logic autoXoff, autoXon, start;

  assign autoXoff = rxFifoFull && !fifoFullQ && !noPauseFifo;
  assign autoXon  = !rxFifoFull && fifoFullQ && !noPauseFifo;
  assign pauseReq = (xoffPend || xonPend) && !dpBusy;
  assign start    = pauseReq && pauseGrant;

  always_comb begin
    strobe.start   = start;
    strobe.sendXon = !xoffPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xoffPend  <= 1'b0;
      xonPend   <= 1'b0;
      fifoFullQ <= 1'b0;
    end else begin
      fifoFullQ <= rxFifoFull;
      xoffPend  <= (xoffPend && !(start && xoffPend)) || cmdXoff || autoXoff;
      xonPend   <= (xonPend && !(start && !xoffPend)) || cmdXon || autoXon;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !pauseGrant) |=> pauseReq) else $error("req dropped"); // R9
  AST_FIFO_RISE_XOFF: assert property (@(posedge clk) disable iff (!rstN)
    (!noPauseFifo && $rose(rxFifoFull)) |=> xoffPend) else $error("no xoff"); // R6
  AST_NO_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    (noPauseFifo && !cmdXoff && !cmdXon && !xoffPend && !xonPend) |=> !pauseReq)
    else $error("auto req while disabled"); // R7
  AST_XON_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && xoffPend && xonPend) |=> xonPend) else $error("xon lost"); // R8
endmodule

// File: rtl/pause_frame_dp.sv
module pause_frame_dp
  import pause_gen_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  parameter int QUANTA_W  = 16,
  parameter int ADDR_W    = 48
) (
  input  logic clk,
  input  logic rstN,
  input  pauseStrobe_t strobe,
  input  logic [QUANTA_W-1:0] pauseQuanta,
  input  logic [ADDR_W-1:0] stationAddr,
  output logic busy,
  output logic txValid,
  output logic [7:0] txData,
  output logic txFirst,
  output logic txLast
);
  localparam int IDX_W   = $clog2(FRAME_LEN);
  localparam int A_BYTES = ADDR_W / 8;
  localparam int Q_BYTES = QUANTA_W / 8;
  localparam int SA_OFF  = A_BYTES;
  localparam int TY_OFF  = SA_OFF + A_BYTES;
  localparam int OP_OFF  = TY_OFF + 2;
  localparam int Q_OFF   = OP_OFF + 2;
  localparam int PAD_OFF = Q_OFF + Q_BYTES;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic active;
  logic [IDX_W-1:0] idx;
  logic [QUANTA_W-1:0] qReg;
  logic [ADDR_W-1:0] saReg;
  logic [ADDR_W-1:0] daShift, saShift;
  logic [QUANTA_W-1:0] qShift;
  logic [15:0] tyShift, opShift;
  logic [7:0] byteMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      idx    <= '0;
      qReg   <= '0;
      saReg  <= '0;
    end else if (strobe.start) begin
      active <= 1'b1;
      idx    <= '0;
      qReg   <= strobe.sendXon ? '0 : pauseQuanta;
      saReg  <= stationAddr;
    end else if (active) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    int off;
    off     = int'(idx);
    daShift = ADDR_W'(PAUSE_DEST) >> (8 * (A_BYTES - 1 - off));
    saShift = saReg >> (8 * (A_BYTES - 1 - (off - SA_OFF)));
    tyShift = PAUSE_TYPE >> (8 * (1 - (off - TY_OFF)));
    opShift = PAUSE_OPCODE >> (8 * (1 - (off - OP_OFF)));
    qShift  = qReg >> (8 * (Q_BYTES - 1 - (off - Q_OFF)));
    if (off < SA_OFF)       byteMux = daShift[7:0];
    else if (off < TY_OFF)  byteMux = saShift[7:0];
    else if (off < OP_OFF)  byteMux = tyShift[7:0];
    else if (off < Q_OFF)   byteMux = opShift[7:0];
    else if (off < PAD_OFF) byteMux = qShift[7:0];
    else                    byteMux = 8'h00;
  end

  assign busy    = active;
  assign txValid = active;
  assign txData  = active ? byteMux : 8'h00;
  assign txFirst = active && (idx == '0);
  assign txLast  = active && (idx == LAST_IDX);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> !txValid) else $error("start during frame"); // R10
  AST_FIRST_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (txValid && txFirst)) else $error("no first byte"); // R2
  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txLast) |=> (txValid && !txFirst)) else $error("gap in frame"); // R2
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    txLast |=> !txValid) else $error("valid after last"); // R2
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_gen_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  parameter int QUANTA_W  = 16,
  parameter int ADDR_W    = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdXoff,
  input  logic cmdXon,
  input  logic rxFifoFull,
  input  logic noPauseFifo,
  input  logic [QUANTA_W-1:0] pauseQuanta,
  input  logic [ADDR_W-1:0] stationAddr,
  output logic pauseReq,
  input  logic pauseGrant,
  output logic txValid,
  output logic [7:0] txData,
  output logic txFirst,
  output logic txLast
);
  pauseStrobe_t strobe;
  logic dpBusy;

  pause_req_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdXoff(cmdXoff), .cmdXon(cmdXon),
    .rxFifoFull(rxFifoFull), .noPauseFifo(noPauseFifo),
    .pauseGrant(pauseGrant), .dpBusy(dpBusy),
    .pauseReq(pauseReq), .strobe(strobe)
  );

  pause_frame_dp #(.FRAME_LEN(FRAME_LEN), .QUANTA_W(QUANTA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pauseQuanta(pauseQuanta),
    .stationAddr(stationAddr), .busy(dpBusy), .txValid(txValid),
    .txData(txData), .txFirst(txFirst), .txLast(txLast)
  );

  AST_NO_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !pauseReq) else $error("req during frame"); // R10
endmodule

// File: tb/pause_frame_gen_bench.sv
module pause_frame_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FLEN = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdXoff = 0, cmdXon = 0, rxFifoFull = 0, noPauseFifo = 0, pauseGrant = 0;
  logic [15:0] pauseQuanta = '0;
  logic [47:0] stationAddr = '0;
  logic pauseReq, txValid, txFirst, txLast;
  logic [7:0] txData;

  int checks = 0;
  int errors = 0;
  logic [7:0] capBuf [FLEN];
  int markErr;

  // vector: {isXon, quanta, station address}
  localparam logic [64:0] VEC [4] = '{
    {1'b0, 16'hFFFF, 48'h001122334455},
    {1'b1, 16'h1234, 48'hA0B0C0D0E0F0},
    {1'b0, 16'h0001, 48'h0200DEADBEEF},
    {1'b0, 16'h8000, 48'hFFFFFFFFFFFE}
  };

  always #(CLK_PERIOD / 2) clk = ~clk;

  pause_frame_gen u_pause_frame_gen (
    .clk(clk), .rstN(rstN), .cmdXoff(cmdXoff), .cmdXon(cmdXon),
    .rxFifoFull(rxFifoFull), .noPauseFifo(noPauseFifo),
    .pauseQuanta(pauseQuanta), .stationAddr(stationAddr),
    .pauseReq(pauseReq), .pauseGrant(pauseGrant), .txValid(txValid),
    .txData(txData), .txFirst(txFirst), .txLast(txLast)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int i, input logic [47:0] sa,
                                         input logic [15:0] q);
    logic [7:0] da [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6) return da[i];
    if (i < 12) return sa[8*(11-i) +: 8];
    case (i)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic pulse(input bit xoff, input bit xon);
    cmdXoff = xoff; cmdXon = xon;
    @(negedge clk);
    cmdXoff = 0; cmdXon = 0;
  endtask

  task automatic grant();
    pauseGrant = 1;
    @(negedge clk);
    pauseGrant = 0;
  endtask

  // now at negedge showing byte 0; leaves at negedge after last byte
  task automatic captureFrame();
    markErr = 0;
    for (int i = 0; i < FLEN; i++) begin
      capBuf[i] = txData;
      if (txValid !== 1'b1 || txFirst !== (i == 0) || txLast !== (i == FLEN - 1))
        markErr++;
      @(negedge clk);
    end
  endtask

  task automatic checkFrame(input string tag, input logic [47:0] sa,
                            input logic [15:0] q);
    int bad = -1;
    for (int i = FLEN - 1; i >= 0; i--)
      if (capBuf[i] !== expByte(i, sa, q)) bad = i;
    if (bad < 0) check(1, tag, "frame bytes", 0, 0);
    else check(0, tag, $sformatf("byte %0d", bad), 64'(capBuf[bad]),
               64'(expByte(bad, sa, q)));
    check(markErr == 0, "R2", "valid/first/last markers", 64'(markErr), 0);
    check(txValid == 0, "R2", "valid low after last byte", 64'(txValid), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({pauseReq, txValid, txFirst, txLast} == 4'b0, "R1", "outputs in reset",
          64'({pauseReq, txValid, txFirst, txLast}), 0);
    rstN = 1;
    @(negedge clk);
    check({pauseReq, txValid} == 2'b0, "R1", "outputs after reset",
          64'({pauseReq, txValid}), 0);

    // table-driven command frames
    for (int v = 0; v < 4; v++) begin
      logic isXon;
      logic [15:0] q;
      logic [47:0] sa;
      {isXon, q, sa} = VEC[v];
      pauseQuanta = q; stationAddr = sa;
      pulse(!isXon, isXon);
      check(pauseReq == 1, "R2", "request after command", 64'(pauseReq), 1);
      pauseGrant = 1;
      @(negedge clk);
      pauseGrant = 0;
      pauseQuanta = ~q;  // R4: change after accept must not matter
      stationAddr = ~sa;
      captureFrame();
      checkFrame(isXon ? "R5" : "R4", sa, isXon ? 16'h0000 : q);
    end

    // R9: request held without grant, no frame
    pauseQuanta = 16'h0A0B; stationAddr = 48'h0C0D0E0F1011;
    pulse(1, 0);
    repeat (20) @(negedge clk);
    check(pauseReq == 1 && txValid == 0, "R9", "held request, no frame",
          64'({pauseReq, txValid}), 64'h2);
    grant();
    captureFrame();
    checkFrame("R3", 48'h0C0D0E0F1011, 16'h0A0B);
    grant();  // grant with no request
    check(txValid == 0 && pauseReq == 0, "R9", "stray grant ignored",
          64'({pauseReq, txValid}), 0);

    // R8: both pending -> XOFF first then XON
    pauseQuanta = 16'h5566;
    pulse(1, 1);
    grant();
    captureFrame();
    checkFrame("R8", 48'h0C0D0E0F1011, 16'h5566);
    check(pauseReq == 1, "R8", "xon still requested", 64'(pauseReq), 1);
    grant();
    captureFrame();
    checkFrame("R8", 48'h0C0D0E0F1011, 16'h0000);

    // R10: command during frame
    pulse(1, 0);
    grant();
    repeat (10) @(negedge clk);
    pulse(0, 1);
    check(pauseReq == 0 && txValid == 1, "R10", "no request mid-frame",
          64'({pauseReq, txValid}), 64'h1);
    repeat (FLEN - 12) @(negedge clk);
    check(txLast == 1 && pauseReq == 0, "R10", "last byte, request low",
          64'({txLast, pauseReq}), 64'h2);
    @(negedge clk);
    check(pauseReq == 1 && txValid == 0, "R10", "request after frame",
          64'({pauseReq, txValid}), 64'h2);
    grant();
    captureFrame();
    checkFrame("R5", 48'h0C0D0E0F1011, 16'h0000);

    // R6: FIFO-driven XOFF/XON
    pauseQuanta = 16'h7777;
    rxFifoFull = 1;
    @(negedge clk);
    check(pauseReq == 1, "R6", "request on fifo full", 64'(pauseReq), 1);
    grant();
    captureFrame();
    checkFrame("R6", 48'h0C0D0E0F1011, 16'h7777);
    check(pauseReq == 0, "R6", "no repeat while full", 64'(pauseReq), 0);
    rxFifoFull = 0;
    @(negedge clk);
    check(pauseReq == 1, "R6", "request on fifo recovery", 64'(pauseReq), 1);
    grant();
    captureFrame();
    checkFrame("R6", 48'h0C0D0E0F1011, 16'h0000);

    // R7: automatic generation disabled
    noPauseFifo = 1;
    rxFifoFull = 1;
    repeat (5) @(negedge clk);
    check(pauseReq == 0, "R7", "no request on full when disabled", 64'(pauseReq), 0);
    rxFifoFull = 0;
    repeat (5) @(negedge clk);
    check(pauseReq == 0 && txValid == 0, "R7", "no request on recovery when disabled",
          64'({pauseReq, txValid}), 0);
    pulse(1, 0);
    check(pauseReq == 1, "R7", "commands still work when disabled", 64'(pauseReq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule